// File: doc/BRIEF.md
# Byte-wide SPI Transceiver with Selectable Rate

This block moves one byte at a time over a four-wire serial link. It can act as the bus master, which makes the serial clock, or as a slave, which follows a clock from outside. A live mode input picks the role. Clock polarity and clock phase are live inputs too, so the block can use any of the four usual timing schemes. In master mode the serial clock comes from the system clock through a divider. A three-bit rate code sets the divide ratio. Two bits of the code come from the control inputs. The top bit comes from a separate one-bit option register, which clears to zero on reset.

To start a master transfer, software pulses the load strobe with a transmit byte. The block then shifts that byte out MSB first and shifts in a byte from the far end at the same time. When the frame ends it shows the received byte and raises a completion flag for one cycle. In slave mode the byte is loaded ahead of time while the block is idle. The block then waits for the select line to fall. It shifts only on edges of the external clock, after those edges pass through a synchroniser. The polarity, phase, mode and rate in force when a frame starts are held fixed until that frame ends.

Top module: `spi_xcvr`

## Requirements
- R1: With `cfg_master`=1 the block drives `sck_oe`=1 and toggles `sck_out` during a frame. With `cfg_master`=0, `sck_oe` is 0 and `sck_out` does not move during a frame.
- R2: In master mode `sck_out` rests at the level of `cfg_cpol` while no frame is running, and it returns to that level after the 16th edge of a frame.
- R3: In master mode, a frame lasts exactly 8×D system cycles. The count runs from the clock edge that accepts `tx_load` to the edge that raises `xfer_done`. D is set by the rate code {option bit, `cfg_rate[1]`, `cfg_rate[0]`]: 000→2, 001→4, 010→16, 011→32, 100→8, 101→16, 110→64, 111→128.
- R4: The option bit is 0 after reset. It changes only on a cycle with `opt_wr`=1, when it takes `opt_rate_hi`.
- R5: With phase 0, the MSB is on the data output as soon as the frame starts. Input data is sampled on each odd-numbered SCK edge (1st, 3rd, and so on), and the output moves to the next bit on each even-numbered edge.
- R6: With phase 1, the output moves to the next bit on each odd-numbered edge, starting with the MSB at the 1st edge. Input is sampled on each even-numbered edge.
- R7: Bytes go MSB first in both directions at once. After the 16th SCK edge, `xfer_done` is high for exactly one cycle, and in that same cycle `rx_byte` holds the 8 bits received. Both are 0 after reset.
- R8: Changes to `cfg_cpol`, `cfg_cpha` or `cfg_rate` while a frame is running do not change that frame's timing, data or duration.
- R9: In slave mode a frame starts on a falling edge of `ss_n_in`. Bits move only on edges of `sck_in` while `ss_n_in` is low. Edges of `sck_in` while `ss_n_in` is high start nothing and raise no `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase scheme select |
| cfg_rate | input | 2 | Low two bits of the rate code |
| opt_wr | input | 1 | Write strobe for the option bit |
| opt_rate_hi | input | 1 | Value written to the option bit (rate code MSB) |
| tx_load | input | 1 | Load strobe for the transmit byte (also starts a master frame) |
| tx_byte | input | 8 | Byte to transmit |
| rx_byte | output | 8 | Last byte received |
| xfer_done | output | 1 | One-cycle frame-complete pulse |
| sck_in | input | 1 | Serial clock from outside (slave) |
| sck_out | output | 1 | Serial clock generated (master) |
| sck_oe | output | 1 | Output enable for the serial clock |
| ss_n_in | input | 1 | Active-low slave select |
| mosi_in | input | 1 | Master-out data, received in slave mode |
| mosi_out | output | 1 | Master-out data, driven in master mode |
| mosi_oe | output | 1 | Output enable for master-out data |
| miso_in | input | 1 | Slave-out data, received in master mode |
| miso_out | output | 1 | Slave-out data, driven in slave mode |
| miso_oe | output | 1 | Output enable for slave-out data |

## Verification
The bench runs every rate code. It measures each frame length in system cycles, so a ratio table that was assumed to be monotonic, or an option bit that did not clear on reset, shows up as a wrong length. At the fastest ratio, edges arrive every cycle, so a design that drove and sampled on the same edge would corrupt the received byte. Every polarity and phase pairing is run in both roles, so a phase decode that was swapped or off by one would shift the bytes by one bit. One frame flips polarity, phase and rate in its middle. A design that failed to hold its settings would then stretch or shorten the frame, or lose data. In slave mode the bench toggles the external clock while the select line is high and checks that no frame is counted.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  localparam int RATE_W = 3;
  localparam int HALF_W = 7;

  typedef enum logic {ST_IDLE, ST_RUN} xfer_state_e;

  // system cycles per serial clock half period for each rate code
  function automatic logic [HALF_W-1:0] half_of(input logic [RATE_W-1:0] code);
    logic [HALF_W-1:0] h;
    case (code)
      3'b000:  h = HALF_W'(1);
      3'b001:  h = HALF_W'(2);
      3'b010:  h = HALF_W'(8);
      3'b011:  h = HALF_W'(16);
      3'b100:  h = HALF_W'(4);
      3'b101:  h = HALF_W'(8);
      3'b110:  h = HALF_W'(32);
      default: h = HALF_W'(64);
    endcase
    return h;
  endfunction
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int HW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == half - HW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // two ticks in a row are legal only at the fastest ratio
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half > HW'(1)) |=> !tick);
endmodule

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic q_prev
);
  logic [STAGES:0] chain_q, chain_d;

  assign chain_d = {chain_q[STAGES-1:0], d};
  assign q       = chain_q[STAGES-1];
  assign q_prev  = chain_q[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {(STAGES+1){RST_VAL}};
    else        chain_q <= chain_d;
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          start,
  input  logic          start_cpha,
  input  logic          cpha,
  input  logic          edge_ev,
  input  logic          leading,
  input  logic          din,
  output logic          dout,
  output logic [DW-1:0] rx_next
);
  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d, src;
  logic          out_q, out_d;

  assign src     = load ? load_byte : tx_q;
  assign dout    = out_q;
  assign rx_next = rx_d;

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    out_d = out_q;
    if (start) begin
      rx_d = '0;
      if (!start_cpha) begin
        out_d = src[DW-1];
        tx_d  = {src[DW-2:0], 1'b0};
      end else begin
        tx_d  = src;
      end
    end else if (load) begin
      tx_d = load_byte;
    end else if (edge_ev) begin
      if (leading ^ cpha) begin
        rx_d = {rx_q[DW-2:0], din};
      end else begin
        out_d = tx_q[DW-1];
        tx_d  = {tx_q[DW-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      out_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      out_q <= out_d;
    end
  end
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic [1:0]    cfg_rate,
  input  logic          opt_wr,
  input  logic          opt_rate_hi,
  input  logic          tx_load,
  input  logic [DW-1:0] tx_byte,
  output logic [DW-1:0] rx_byte,
  output logic          xfer_done,
  input  logic          sck_in,
  output logic          sck_out,
  output logic          sck_oe,
  input  logic          ss_n_in,
  input  logic          mosi_in,
  output logic          mosi_out,
  output logic          mosi_oe,
  input  logic          miso_in,
  output logic          miso_out,
  output logic          miso_oe
);
  localparam int EDGES = 2 * DW;
  localparam int CW    = $clog2(EDGES);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // separate option register holding the rate code MSB
  logic opt_q;
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      opt_q <= 1'b0;
    else if (opt_wr) opt_q <= opt_rate_hi;
  end

  // external pins for slave mode
  logic ss_s, ss_p, sck_s, sck_p;
  spi_pin_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ss_sync (
    .clk(clk), .rst_n(rst_s), .d(ss_n_in), .q(ss_s), .q_prev(ss_p));
  spi_pin_sync #(.STAGES(2), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_s), .d(sck_in), .q(sck_s), .q_prev(sck_p));

  xfer_state_e       state_q, state_d;
  logic [CW-1:0]     ecnt_q, ecnt_d;
  logic              mst_q, pol_q, pha_q;
  logic [HALF_W-1:0] half_q;
  logic              sck_q, sck_d;
  logic [DW-1:0]     rxb_q, rxb_d, rx_next;
  logic              done_q, done_d;

  logic act, start_m, start_s, start, edge_ev, abort, last, div_tick, din, dout;

  assign act     = (state_q == ST_RUN);
  assign start_m = !act && cfg_master && tx_load;
  assign start_s = !act && !cfg_master && ss_p && !ss_s;
  assign start   = start_m || start_s;
  assign edge_ev = act && (mst_q ? div_tick : ((sck_s ^ sck_p) && !ss_s));
  assign abort   = act && !mst_q && ss_s;
  assign last    = edge_ev && (ecnt_q == CW'(EDGES - 1));
  assign din     = mst_q ? miso_in : mosi_in;

  spi_rate_div #(.HW(HALF_W)) u_div (
    .clk(clk), .rst_n(rst_s), .run(act && mst_q), .half(half_q), .tick(div_tick));

  spi_shift_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_s),
    .load(tx_load && !act), .load_byte(tx_byte),
    .start(start), .start_cpha(cfg_cpha), .cpha(pha_q),
    .edge_ev(edge_ev && !abort), .leading(!ecnt_q[0]),
    .din(din), .dout(dout), .rx_next(rx_next));

  always_comb begin
    state_d = state_q;
    ecnt_d  = ecnt_q;
    sck_d   = sck_q;
    rxb_d   = rxb_q;
    done_d  = 1'b0;
    if (!act) begin
      sck_d = cfg_cpol;
      if (start) begin
        state_d = ST_RUN;
        ecnt_d  = '0;
      end
    end else if (abort) begin
      state_d = ST_IDLE;
    end else if (edge_ev) begin
      ecnt_d = ecnt_q + CW'(1);
      if (mst_q) sck_d = !sck_q;
      if (last) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        rxb_d   = rx_next;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      ecnt_q  <= '0;
      sck_q   <= 1'b0;
      rxb_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ecnt_q  <= ecnt_d;
      sck_q   <= sck_d;
      rxb_q   <= rxb_d;
      done_q  <= done_d;
    end
  end

  // frame settings, captured only at frame start
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      mst_q  <= 1'b0;
      pol_q  <= 1'b0;
      pha_q  <= 1'b0;
      half_q <= HALF_W'(1);
    end else if (start) begin
      mst_q  <= cfg_master;
      pol_q  <= cfg_cpol;
      pha_q  <= cfg_cpha;
      half_q <= half_of({opt_q, cfg_rate});
    end
  end

  assign rx_byte   = rxb_q;
  assign xfer_done = done_q;
  assign sck_out   = sck_q;
  assign sck_oe    = cfg_master;
  assign mosi_out  = dout;
  assign mosi_oe   = cfg_master;
  assign miso_out  = dout;
  assign miso_oe   = !cfg_master && !ss_s;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_s)
    xfer_done |=> !xfer_done);
  assert_idle_return_R2: assert property (@(posedge clk) disable iff (!rst_s)
    ($fell(act) && mst_q) |-> (sck_q == pol_q));
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (act && $past(act)) |-> ($stable(half_q) && $stable(pha_q) && $stable(mst_q)));
  assert_slave_sck_still_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (act && $past(act) && !mst_q) |-> $stable(sck_out));
  assert_slave_deselect_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (act && !mst_q && ss_s) |=> !act);
endmodule

// File: tb/spi_xcvr_test.sv
module spi_xcvr_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cfg_master, cfg_cpol, cfg_cpha, opt_wr, opt_rate_hi, tx_load;
  logic [1:0] cfg_rate;
  logic [7:0] tx_byte, rx_byte;
  logic       xfer_done, sck_in, sck_out, sck_oe, ss_n_in;
  logic       mosi_in, mosi_out, mosi_oe, miso_in, miso_out, miso_oe;

  spi_xcvr uut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_rate(cfg_rate), .opt_wr(opt_wr), .opt_rate_hi(opt_rate_hi),
    .tx_load(tx_load), .tx_byte(tx_byte), .rx_byte(rx_byte), .xfer_done(xfer_done),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .ss_n_in(ss_n_in),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
    .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe));

  int n_chk = 0, n_bad = 0, cyc = 0, done_cnt = 0;
  logic [7:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] code);
    case (code)
      3'd0: return 2;   3'd1: return 4;   3'd2: return 16;  3'd3: return 32;
      3'd4: return 8;   3'd5: return 16;  3'd6: return 64;  default: return 128;
    endcase
  endfunction

  // scoreboard monitor: compare each completed byte with the queue head
  always @(negedge clk) begin
    if (rst_n && xfer_done) begin
      done_cnt++;
      if (exp_q.size() == 0) chk(1'b0, "R7", "done with no frame expected", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_byte == e, "R7", "received byte", rx_byte, e);
      end
    end
  end

  task automatic write_opt(input logic v);
    @(negedge clk); opt_wr = 1'b1; opt_rate_hi = v;
    @(negedge clk); opt_wr = 1'b0;
  endtask

  // master frame against a bench slave model
  task automatic run_master(input logic [7:0] txb, input logic [7:0] slvb, input logic pol,
                            input logic pha, input logic [2:0] code, input bit disturb);
    int bi, edges, start, dur;
    logic prev;
    logic [7:0] got;
    @(negedge clk);
    cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_rate = code[1:0];
    @(negedge clk);
    chk(sck_out == pol, "R2", "idle sck level", sck_out, pol);
    chk(sck_oe == 1'b1, "R1", "master drives sck", sck_oe, 1);
    miso_in = pha ? 1'b0 : slvb[7];
    bi = pha ? 7 : 6;
    exp_q.push_back(slvb);
    tx_byte = txb; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
    start = cyc; prev = sck_out; edges = 0; got = '0; dur = -1;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (disturb && edges == 3) begin
        cfg_cpol = ~pol; cfg_cpha = ~pha; cfg_rate = ~code[1:0];
      end
      if (sck_out != prev) begin
        edges++; prev = sck_out;
        if ((edges % 2 == 1) ^ pha) got = {got[6:0], mosi_out};
        else if (bi >= 0) begin miso_in = slvb[bi]; bi--; end
      end
      if (xfer_done) begin dur = cyc - start; break; end
    end
    chk(dur == 8 * ratio_of(code), disturb ? "R8" : "R3", "frame cycles", dur, 8 * ratio_of(code));
    chk(edges == 16, "R7", "sck edges per frame", edges, 16);
    chk(got == txb, pha ? "R6" : "R5", "byte seen on mosi", got, txb);
    chk(sck_out == pol, "R2", "sck back at idle", sck_out, pol);
    cfg_cpol = pol; cfg_cpha = pha; cfg_rate = code[1:0];
  endtask

  // slave frame driven by a bench master model
  task automatic run_slave(input logic [7:0] mstb, input logic [7:0] slvb, input logic pol, input logic pha);
    logic [7:0] got;
    int d0;
    @(negedge clk);
    cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha; sck_in = pol; ss_n_in = 1'b1;
    repeat (4) @(negedge clk);
    tx_byte = slvb; tx_load = 1'b1;
    @(negedge clk); tx_load = 1'b0;
    chk(sck_oe == 1'b0, "R1", "slave leaves sck undriven", sck_oe, 0);
    exp_q.push_back(mstb);
    d0 = done_cnt; got = '0;
    ss_n_in = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (!pha) begin
        mosi_in = mstb[i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_out};
        sck_in = ~sck_in;
        repeat (8) @(negedge clk);
        sck_in = ~sck_in;
      end else begin
        sck_in = ~sck_in; mosi_in = mstb[i];
        repeat (8) @(negedge clk);
        got = {got[6:0], miso_out};
        sck_in = ~sck_in;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(got == slvb, pha ? "R6" : "R5", "slave byte seen on miso", got, slvb);
    chk(done_cnt == d0 + 1, "R9", "one slave frame completed", done_cnt - d0, 1);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", "run hung", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int d0;
    rst_n = 1'b0; cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_rate = 2'b00;
    opt_wr = 1'b0; opt_rate_hi = 1'b0; tx_load = 1'b0; tx_byte = '0;
    sck_in = 1'b0; ss_n_in = 1'b1; mosi_in = 1'b0; miso_in = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(xfer_done == 1'b0, "R7", "done low after reset", xfer_done, 0);
    chk(rx_byte == 8'h00, "R7", "rx byte after reset", rx_byte, 0);
    chk(sck_out == 1'b0, "R2", "sck after reset", sck_out, 0);
    chk(sck_oe == 1'b0, "R1", "slave after reset", sck_oe, 0);

    // option bit clear after reset: code 11 gives ratio 32 (R4)
    run_master(8'hA5, 8'h3C, 1'b0, 1'b0, 3'b011, 1'b0);
    write_opt(1'b1); // R4 option write
    run_master(8'h81, 8'h7E, 1'b1, 1'b0, 3'b100, 1'b0);
    run_master(8'h5A, 8'hC3, 1'b0, 1'b1, 3'b101, 1'b0);
    run_master(8'hF0, 8'h0F, 1'b1, 1'b1, 3'b110, 1'b0);
    run_master(8'h96, 8'h69, 1'b0, 1'b0, 3'b111, 1'b0);
    write_opt(1'b0);
    run_master(8'h01, 8'h80, 1'b0, 1'b1, 3'b000, 1'b0);
    run_master(8'hFF, 8'h00, 1'b1, 1'b0, 3'b000, 1'b0);
    run_master(8'h3E, 8'hD4, 1'b1, 1'b1, 3'b001, 1'b0);
    run_master(8'hC7, 8'h2B, 1'b0, 1'b0, 3'b010, 1'b0);
    // R8: settings flipped mid-frame
    run_master(8'h6D, 8'hB2, 1'b0, 1'b0, 3'b010, 1'b1);
    run_master(8'h92, 8'h4E, 1'b1, 1'b1, 3'b001, 1'b1);

    run_slave(8'hA3, 8'h5C, 1'b0, 1'b0);
    run_slave(8'h1E, 8'hE1, 1'b0, 1'b1);
    run_slave(8'h77, 8'h88, 1'b1, 1'b0);
    run_slave(8'hB4, 8'h4B, 1'b1, 1'b1);

    // R9: clock edges with select high are ignored
    @(negedge clk); cfg_master = 1'b0; ss_n_in = 1'b1;
    d0 = done_cnt;
    for (int t = 0; t < 20; t++) begin
      sck_in = ~sck_in;
      repeat (4) @(negedge clk);
    end
    chk(done_cnt == d0, "R9", "no frame while deselected", done_cnt - d0, 0);
    run_slave(8'hD2, 8'h2D, 1'b0, 1'b0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "frames left unfinished", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule